// File: doc/BRIEF.md
# Horizontal Skew Detector and HD Generator

This block keeps a horizontal reference counter running at four times the colour subcarrier rate. Left alone, it free-runs at the nominal line period. When composite-sync edges arrive close to the reference origin, the counter is nudged toward them by a bounded step on each line, so it follows the incoming line rate.

Every accepted sync edge has its position measured against the reference. That offset is rounded to the nearest fifth of a line, which gives a skew code. A downstream line-memory delay selector uses the code to realign video that has slipped horizontally. A new code is adopted only after the same bin has been seen on two successive detections, and each adoption is announced with a one-cycle strobe.

A pseudo-vertical mask stops detection, steering and loss counting during the vertical interval. The mask can be read with either polarity. A single output pin carries one of three signals:

- in skew mode, a horizontal-drive pulse aligned to the corrected video;
- in skew mode, that pulse OR'd with the mask;
- outside skew mode, the raw sync delayed by a fixed number of clocks.

Top module: `skew_hd_gen`

## Requirements
- R1: The reference counter counts 0 to LINE_CLKS-1 and wraps. With no steering edge it returns to 0 exactly LINE_CLKS clocks after it last left 0. The HD pulse is high while the counter is below HD_CLKS.
- R2: Let p be the counter value at the clock that sees a detected rising edge. Its signed error e is p when p < LINE_CLKS/2, and p-LINE_CLKS otherwise. When |e| < BIN_CLKS/2, the next counter value is (p + 1 - s) modulo LINE_CLKS, where s is e clamped to ±MAX_STEP. Edges outside that window do not steer.
- R3: The bin of a detected edge is ((p + BIN_CLKS/2) / BIN_CLKS) mod NUM_BINS, using integer division. skew_code always stays below NUM_BINS.
- R4: skew_code takes a new bin only when that bin equals the bin of the previous detection, and the previous detection is still pending. skew_vld pulses for one clock at that moment. It is visible after the same clock edge that saw the second sync edge.
- R5: The mask is active when pv_in XOR pv_pol is 1. While the mask is active, no detection, steering or skew_vld occurs, and a line end is not counted as a missed line.
- R6: If LOSS_LINES consecutive line ends pass with no detection, and the mask is inactive at each of them, skew_code returns to 0 and the pending bin is dropped.
- R7: With skew_en=1, sync_out is the HD pulse when sync_sel=0. When sync_sel=1 it is the HD pulse OR the active mask.
- R8: With skew_en=0, sync_out is csync_in delayed by SYNC_DLY clocks. While skew_en is 0, detection is off and skew_code is held at 0.
- R9: Detection is on the rising edge of csync_in only. A pulse one clock wide is accepted. A held-high level does not re-trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4fsc sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csync_in | input | 1 | Separated composite sync, high during sync |
| pv_in | input | 1 | Pseudo-vertical mask input |
| pv_pol | input | 1 | 1 reads the mask as active-low |
| skew_en | input | 1 | Skew correction mode enable |
| sync_sel | input | 1 | In skew mode, 1 ORs the mask onto the HD pulse |
| skew_code | output | $clog2(NUM_BINS) | Confirmed skew bin |
| skew_vld | output | 1 | One-clock strobe when a bin is confirmed |
| sync_out | output | 1 | HD, HD+mask, or delayed sync |

## Verification
skew_code and skew_vld are registered: they change after the clock edge at which csync_in is first seen high, one edge after the stimulus is applied. The bench drives inputs on the falling edge and steps its own arithmetic model through that same rising edge. It then compares on the next falling edge.

The reference counter also advances at that edge, including any steering. The HD part of sync_out is therefore due in the same cycle. The mask term depends on pv_in combinationally and is compared against the pv_in present at the sampling point. The pass-through sync is due SYNC_DLY edges after it is driven.

Sweeping every phase of a short line exercises all bins, the steering window and the rounding boundaries.

// File: rtl/skew_pkg.sv
package skew_pkg;

  // Signed distance of a reference phase from the line origin.
  function automatic int phase_err(input int ph, input int line);
    return (ph < line / 2) ? ph : ph - line;
  endfunction

  // Nearest fifth-of-line (or generic) bin, rounding at the half bin.
  function automatic int bin_of(input int ph, input int bin, input int nbins);
    return ((ph + bin / 2) / bin) % nbins;
  endfunction

  // Bounded correction per detected edge.
  function automatic int clamp_step(input int e, input int lim);
    if (e > lim) return lim;
    if (e < -lim) return -lim;
    return e;
  endfunction

  // Modular add inside one line.
  function automatic int wrap_add(input int v, input int d, input int line);
    int t;
    t = v + d;
    if (t < 0) t = t + line;
    else if (t >= line) t = t - line;
    return t;
  endfunction

endpackage

// File: rtl/skew_ref_counter.sv
module skew_ref_counter #(
  parameter int LINE_CLKS = 910,
  parameter int BIN_CLKS  = 182,
  parameter int MAX_STEP  = 16,
  parameter int CW        = $clog2(LINE_CLKS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          det,
  output logic [CW-1:0] ref_cnt,
  output logic          wrap,
  output logic          steer
);
  localparam int LAST = LINE_CLKS - 1;

  int err;
  int step;
  int nxt;

  always_comb begin
    err   = skew_pkg::phase_err(int'(ref_cnt), LINE_CLKS);
    step  = skew_pkg::clamp_step(err, MAX_STEP);
    steer = det && (err < BIN_CLKS / 2) && (err > -(BIN_CLKS / 2));
    wrap  = (int'(ref_cnt) == LAST);
    if (steer) nxt = skew_pkg::wrap_add(int'(ref_cnt), 1 - step, LINE_CLKS);
    else       nxt = skew_pkg::wrap_add(int'(ref_cnt), 1, LINE_CLKS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref_cnt <= '0;
    else        ref_cnt <= CW'(nxt);
  end

  a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ref_cnt) < LINE_CLKS);
  a_r1_free_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!steer && int'(ref_cnt) != LAST) |=> int'(ref_cnt) == int'($past(ref_cnt)) + 1);
  a_r1_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!steer && int'(ref_cnt) == LAST) |=> ref_cnt == '0);

endmodule

// File: rtl/skew_bin_filter.sv
module skew_bin_filter #(
  parameter int NUM_BINS   = 5,
  parameter int LOSS_LINES = 2,
  parameter int BW         = $clog2(NUM_BINS),
  parameter int MW         = $clog2(LOSS_LINES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          skew_en,
  input  logic          det,
  input  logic [BW-1:0] bin,
  input  logic          wrap,
  input  logic          pv_act,
  output logic [BW-1:0] skew_code,
  output logic          skew_vld
);
  logic [BW-1:0] cand;
  logic          cand_v;
  logic          seen;
  logic [MW-1:0] miss;
  logic          confirm;
  logic          lost;

  assign confirm = det && cand_v && (cand == bin);
  assign lost    = wrap && !seen && !det && !pv_act && (int'(miss) + 1 == LOSS_LINES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skew_code <= '0;
      skew_vld  <= 1'b0;
      cand      <= '0;
      cand_v    <= 1'b0;
      seen      <= 1'b0;
      miss      <= '0;
    end else if (!skew_en) begin
      skew_code <= '0;
      skew_vld  <= 1'b0;
      cand_v    <= 1'b0;
      seen      <= 1'b0;
      miss      <= '0;
    end else begin
      skew_vld <= confirm;
      if (confirm) skew_code <= bin;
      if (det) begin
        cand   <= bin;
        cand_v <= 1'b1;
      end
      if (wrap) begin
        seen <= 1'b0;
        if (seen || det) miss <= '0;
        else if (!pv_act) begin
          if (lost) begin
            miss      <= '0;
            skew_code <= '0;
            cand_v    <= 1'b0;
          end else begin
            miss <= miss + 1'b1;
          end
        end
      end else if (det) begin
        seen <= 1'b1;
      end
    end
  end

  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(skew_code) < NUM_BINS);
  a_r4_vld_after_det: assert property (@(posedge clk) disable iff (!rst_n)
    skew_vld |-> $past(det));
  a_r5_mask_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    skew_vld |-> !$past(pv_act));
  a_r8_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !skew_en |=> (skew_code == '0 && !skew_vld));

endmodule

// File: rtl/skew_sync_out.sv
module skew_sync_out #(
  parameter int SYNC_DLY = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic csync_in,
  input  logic hd,
  input  logic pv_act,
  input  logic skew_en,
  input  logic sync_sel,
  output logic sync_out
);
  logic [SYNC_DLY-1:0] dly;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dly[0] <= 1'b0;
    else        dly[0] <= csync_in;
  end

  for (genvar i = 1; i < SYNC_DLY; i++) begin : g_dly
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dly[i] <= 1'b0;
      else        dly[i] <= dly[i-1];
    end
  end

  assign sync_out = skew_en ? (hd | (sync_sel & pv_act)) : dly[SYNC_DLY-1];

  a_r7_hd_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_en && hd) |-> sync_out);

endmodule

// File: rtl/skew_hd_gen.sv
module skew_hd_gen #(
  parameter int LINE_CLKS  = 910,
  parameter int NUM_BINS   = 5,
  parameter int BIN_CLKS   = LINE_CLKS / NUM_BINS,
  parameter int MAX_STEP   = 16,
  parameter int HD_CLKS    = 63,
  parameter int SYNC_DLY   = 8,
  parameter int LOSS_LINES = 2,
  parameter int CW         = $clog2(LINE_CLKS),
  parameter int BW         = $clog2(NUM_BINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          csync_in,
  input  logic          pv_in,
  input  logic          pv_pol,
  input  logic          skew_en,
  input  logic          sync_sel,
  output logic [BW-1:0] skew_code,
  output logic          skew_vld,
  output logic          sync_out
);
  logic          csync_d;
  logic          rise;
  logic          pv_act;
  logic          det;
  logic [CW-1:0] ref_cnt;
  logic          wrap;
  logic          steer;
  logic [BW-1:0] bin;
  logic          hd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) csync_d <= 1'b0;
    else        csync_d <= csync_in;
  end

  assign rise   = csync_in & ~csync_d;
  assign pv_act = pv_in ^ pv_pol;
  assign det    = rise & skew_en & ~pv_act;
  assign bin    = BW'(skew_pkg::bin_of(int'(ref_cnt), BIN_CLKS, NUM_BINS));
  assign hd     = (int'(ref_cnt) < HD_CLKS);

  skew_ref_counter #(
    .LINE_CLKS(LINE_CLKS), .BIN_CLKS(BIN_CLKS), .MAX_STEP(MAX_STEP), .CW(CW)
  ) u_ref (
    .clk(clk), .rst_n(rst_n), .det(det),
    .ref_cnt(ref_cnt), .wrap(wrap), .steer(steer)
  );

  skew_bin_filter #(
    .NUM_BINS(NUM_BINS), .LOSS_LINES(LOSS_LINES), .BW(BW)
  ) u_filt (
    .clk(clk), .rst_n(rst_n), .skew_en(skew_en), .det(det), .bin(bin),
    .wrap(wrap), .pv_act(pv_act), .skew_code(skew_code), .skew_vld(skew_vld)
  );

  skew_sync_out #(.SYNC_DLY(SYNC_DLY)) u_out (
    .clk(clk), .rst_n(rst_n), .csync_in(csync_in), .hd(hd), .pv_act(pv_act),
    .skew_en(skew_en), .sync_sel(sync_sel), .sync_out(sync_out)
  );

  a_r5_no_steer_masked: assert property (@(posedge clk) disable iff (!rst_n)
    pv_act |-> !steer);
  a_r9_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    $past(csync_in) |-> !steer);

endmodule

// File: tb/skew_hd_gen_tb.sv
`timescale 1ns/1ps
module skew_hd_gen_tb;
  localparam int L = 50, NB = 5, B = 10, MS = 2, HDC = 6, DL = 3, LS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csync_in = 1'b0, pv_in = 1'b0, pv_pol = 1'b0, skew_en = 1'b1, sync_sel = 1'b0;
  logic [2:0] skew_code;
  logic skew_vld, sync_out;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string tag = "R1";

  int m_ref = 0, m_cd = 0, m_code = 0, m_cand = 0, m_cv = 0, m_vld = 0;
  int m_seen = 0, m_miss = 0;
  int m_dly[DL];
  int hi = 0;

  always #4 clk = ~clk;

  skew_hd_gen #(.LINE_CLKS(L), .NUM_BINS(NB), .BIN_CLKS(B), .MAX_STEP(MS),
    .HD_CLKS(HDC), .SYNC_DLY(DL), .LOSS_LINES(LS)) u_dut (
    .clk(clk), .rst_n(rst_n), .csync_in(csync_in), .pv_in(pv_in), .pv_pol(pv_pol),
    .skew_en(skew_en), .sync_sel(sync_sel), .skew_code(skew_code),
    .skew_vld(skew_vld), .sync_out(sync_out));

  task automatic check_all();
    int pva, exp_out;
    pva = int'(pv_in ^ pv_pol);
    exp_out = skew_en ? int'((m_ref < HDC) || (sync_sel && pva)) : m_dly[DL-1];
    n_chk += 3;
    if (int'(skew_code) != m_code) begin
      n_bad++; $display("FAIL %s skew_code got %0d exp %0d", tag, skew_code, m_code);
    end
    if (int'(skew_vld) != m_vld) begin
      n_bad++; $display("FAIL %s skew_vld got %0d exp %0d", tag, skew_vld, m_vld);
    end
    if (int'(sync_out) != exp_out) begin
      n_bad++; $display("FAIL %s sync_out got %0d exp %0d", tag, sync_out, exp_out);
    end
  endtask

  // One clock: inputs are already on the pins; model predicts the rising edge.
  task automatic cyc();
    int c, pva, det, e, s, nref, wrap, bin;
    c = int'(csync_in);
    pva = int'(pv_in ^ pv_pol);
    det = (c == 1 && m_cd == 0 && skew_en && pva == 0) ? 1 : 0;
    e = (m_ref < L / 2) ? m_ref : m_ref - L;
    s = (e > MS) ? MS : ((e < -MS) ? -MS : e);
    nref = m_ref + 1;
    if (det && e > -(B / 2) && e < B / 2) nref = m_ref + 1 - s;
    nref = (nref + L) % L;
    wrap = (m_ref == L - 1);
    bin = ((m_ref + B / 2) / B) % NB;
    if (!skew_en) begin
      m_code = 0; m_vld = 0; m_cv = 0; m_seen = 0; m_miss = 0;
    end else begin
      m_vld = (det && m_cv && m_cand == bin) ? 1 : 0;
      if (m_vld) m_code = bin;
      if (det) begin m_cand = bin; m_cv = 1; end
      if (wrap) begin
        if (m_seen || det) m_miss = 0;
        else if (pva == 0) begin
          if (m_miss + 1 == LS) begin m_miss = 0; m_code = 0; m_cv = 0; end
          else m_miss++;
        end
        m_seen = 0;
      end else if (det) m_seen = 1;
    end
    for (int i = DL - 1; i > 0; i--) m_dly[i] = m_dly[i-1];
    m_dly[0] = c;
    m_cd = c;
    m_ref = nref;
    @(negedge clk);
    check_all();
  endtask

  // Run n clocks, starting a pulse of width w whenever the reference hits ph.
  task automatic run(input int n, input int ph, input int w);
    for (int k = 0; k < n; k++) begin
      if (hi == 0 && ph >= 0 && m_ref == ph) hi = w;
      csync_in = (hi > 0);
      if (hi > 0) hi--;
      cyc();
    end
  endtask

  initial begin
    for (int i = 0; i < DL; i++) m_dly[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1 reset";
    check_all();
    tag = "R1 free-run";
    run(2 * L, -1, 1);
    // Every phase, varying pulse width: bins, rounding, steering window, confirmation.
    for (int o = 0; o < L; o++) begin
      tag = "R2 R3 R4 R9 sweep";
      run(3 * L, o, (o % 3) + 1);
    end
    tag = "R9 held level";
    csync_in = 1'b1;
    repeat (2 * L) cyc();
    tag = "R4 noise reject";
    run(3 * L, 30, 2);
    run(L, 10, 2);
    run(2 * L, 30, 2);
    tag = "R5 mask high";
    pv_in = 1'b1; pv_pol = 1'b0;
    run(3 * L, 20, 2);
    tag = "R5 mask polarity";
    pv_pol = 1'b1;
    run(3 * L, 20, 2);
    pv_in = 1'b0;
    run(3 * L, 40, 2);
    tag = "R7 hd plus mask";
    sync_sel = 1'b1;
    run(L, -1, 1);
    pv_in = 1'b1;
    run(L, -1, 1);
    tag = "R6 loss";
    run(3 * L, -1, 1);
    run(3 * L, 10, 2);
    pv_in = 1'b0;
    run(5 * L, -1, 1);
    pv_in = 1'b1;
    tag = "R6 loss after mask";
    run(3 * L, -1, 1);
    tag = "R8 passthrough";
    skew_en = 1'b0;
    run(3 * L, 7, 4);
    run(L, 21, 1);
    skew_en = 1'b1;
    tag = "R7 hd only";
    sync_sel = 1'b0;
    run(3 * L, 0, 3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule